// File: doc/BRIEF.md
# Auxiliary Data RAM Steering Unit

This unit sits between an 8051-style core and its data-memory paths. Every external-data-memory access the core issues is routed either to a 1 KB on-chip RAM or to the external memory bus. The access arrives in one of two addressing forms: a narrow form carrying an 8-bit register pointer, or a wide form carrying a 16-bit data pointer. The unit also holds two special-function registers. A control register contains the RAM disable bit. A page register supplies the upper address bits for narrow accesses.

On-chip hits finish without touching the external bus. An access that misses the window, or any access while the RAM is disabled, goes out as a bus request. The request holds until the bus acknowledges it. Activity flags for the address/data port, the high-address port and the read and write strobes tell the pad logic when the external pins are in use. While code runs from external program memory, both ports are taken by instruction fetch.

Top module: `auxram_steer`

## Requirements
- R1: The on-chip RAM holds 1024 bytes at data addresses 0x000 to 0x3FF. With the RAM enabled, a wide access at or below 0x3FF is served on-chip, and a byte written there reads back unchanged.
- R2: Control register (sfr_sel = 0) bit 1 disables the RAM when set to 1. The register resets to 0x00, so the RAM is enabled after reset. While bit 1 is 1, every access of either form goes to the external bus.
- R3: With the RAM enabled, a narrow access never raises ext_req.
- R4: A narrow access uses the RAM address {page[1:0], req_ptr}.
- R5: A wide access to an address above 0x3FF raises ext_req with ext_addr equal to the full 16-bit data pointer.
- R6: When run_internal is 1, an on-chip access leaves port_ad_active, port_hi_active, rd_strobe and wr_strobe at 0. When run_internal is 0, port_ad_active and port_hi_active are 1 because instruction fetch owns those ports.
- R7: With the RAM disabled, a narrow access goes external with ext_addr = {8'h00, req_ptr}. port_hi_active stays 0 for that access when run_internal is 1.
- R8: The page register (sfr_sel = 1) stores only its 2 low bits. page_rd returns the upper 6 bits as 0, and the register resets to 0.
- R9: For an on-chip access, done is a one-cycle pulse in the cycle after the request. For a read, rdata is valid in that same cycle.
- R10: An external access holds ext_req, ext_addr, ext_write and ext_wdata until ext_ack is sampled. It drives rd_strobe or wr_strobe to match the direction. done pulses in the cycle after ext_ack, and for a read, rdata then equals the ext_rdata sampled with the acknowledge.
- R11: A request made while an external access is pending is ignored. It neither writes the RAM nor starts another access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 1 | Register select: 0 control, 1 page |
| sfr_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register value |
| page_rd | output | 8 | Page register value, upper bits zero |
| run_internal | input | 1 | Code is executing from internal program memory |
| req_valid | input | 1 | Access request |
| req_wide | input | 1 | 1: data-pointer form, 0: register-pointer form |
| req_write | input | 1 | 1: write, 0: read |
| req_ptr | input | 8 | Register pointer |
| req_dptr | input | 16 | Data pointer |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| done | output | 1 | Access complete pulse |
| ext_req | output | 1 | External bus request |
| ext_addr | output | 16 | External address |
| ext_write | output | 1 | External direction |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External bus acknowledge |
| ext_rdata | input | 8 | External read data |
| port_ad_active | output | 1 | Address/data port in use |
| port_hi_active | output | 1 | High-address port in use |
| rd_strobe | output | 1 | Read strobe active |
| wr_strobe | output | 1 | Write strobe active |

## Verification
The bench targets the 0x3FF/0x400 edge with wide accesses. A window compare that is off by one either sends 0x400 into the RAM or pushes 0x3FF out to the bus. It writes page values with set upper bits and then reads through the wide form. A missing mask or a wrong concatenation shows up as aliased data or nonzero readback. It flips the disable bit between accesses and checks pin flags on every on-chip hit. A design that ignores the bit, drives strobes on hits, or accepts a request mid-transaction then produces a wrong route, a stray strobe, or corrupted RAM contents.

// File: rtl/auxram_pkg.sv
package auxram_pkg;
  typedef enum logic {ST_IDLE, ST_EXT} steer_state_t;
  typedef enum logic {SFR_CTRL = 1'b0, SFR_PAGE = 1'b1} sfr_sel_t;
endpackage

// File: rtl/auxram_sfr.sv
module auxram_sfr import auxram_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              ram_en
);
  logic              ctrl_load, page_load;
  logic [DATA_W-1:0] ctrl_d;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    ctrl_load = we && (sel == SFR_CTRL);
    page_load = we && (sel == SFR_PAGE);
    ctrl_d    = wdata;
    page_d    = wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      page_q <= '0;
    end else begin
      if (ctrl_load) ctrl_q <= ctrl_d;
      if (page_load) page_q <= page_d;
    end
  end

  assign ram_en = ~ctrl_q[EN_BIT];
endmodule

// File: rtl/auxram_route.sv
module auxram_route #(
  parameter int unsigned BUS_AW = 16,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned RAM_AW = 10,
  localparam int unsigned PAGE_W = RAM_AW - PTR_W
) (
  input  logic              wide,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [BUS_AW-1:0] dptr,
  input  logic [PAGE_W-1:0] page,
  input  logic              ram_en,
  output logic              onchip,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BUS_AW-1:0] ext_addr,
  output logic              hi_used
);
  logic in_window;

  always_comb begin
    in_window = (dptr[BUS_AW-1:RAM_AW] == '0);
    onchip    = ram_en && (!wide || in_window);
    ram_addr  = wide ? dptr[RAM_AW-1:0] : {page, ptr};
    ext_addr  = wide ? dptr : {{(BUS_AW-PTR_W){1'b0}}, ptr};
    hi_used   = wide;
  end
endmodule

// File: rtl/auxram_store.sv
module auxram_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAM_AW = 10,
  localparam int unsigned DEPTH = 1 << RAM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/auxram_steer.sv
module auxram_steer import auxram_pkg::*; #(
  parameter int unsigned BUS_AW = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned RAM_AW = 10,
  parameter int unsigned EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic              sfr_sel,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] page_rd,
  input  logic              run_internal,
  input  logic              req_valid,
  input  logic              req_wide,
  input  logic              req_write,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [BUS_AW-1:0] req_dptr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ext_req,
  output logic [BUS_AW-1:0] ext_addr,
  output logic              ext_write,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              port_ad_active,
  output logic              port_hi_active,
  output logic              rd_strobe,
  output logic              wr_strobe
);
  localparam int unsigned PAGE_W = RAM_AW - PTR_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DATA_W-1:0] ctrl_q;
  logic [PAGE_W-1:0] page_q;
  logic              ram_en;

  auxram_sfr #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .EN_BIT(EN_BIT)) u_sfr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (sfr_we),
    .sel    (sfr_sel),
    .wdata  (sfr_wdata),
    .ctrl_q (ctrl_q),
    .page_q (page_q),
    .ram_en (ram_en)
  );

  logic              rt_onchip, rt_hi;
  logic [RAM_AW-1:0] rt_ram_addr;
  logic [BUS_AW-1:0] rt_ext_addr;

  auxram_route #(.BUS_AW(BUS_AW), .PTR_W(PTR_W), .RAM_AW(RAM_AW)) u_route (
    .wide     (req_wide),
    .ptr      (req_ptr),
    .dptr     (req_dptr),
    .page     (page_q),
    .ram_en   (ram_en),
    .onchip   (rt_onchip),
    .ram_addr (rt_ram_addr),
    .ext_addr (rt_ext_addr),
    .hi_used  (rt_hi)
  );

  steer_state_t      state_q, state_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_load;
  logic [BUS_AW-1:0] xaddr_q;
  logic              xwr_q, xhi_q;
  logic [DATA_W-1:0] xdata_q;
  logic              x_load;
  logic              take, ram_we;
  logic [DATA_W-1:0] ram_rdata;

  assign take   = req_valid && (state_q == ST_IDLE);
  assign ram_we = take && rt_onchip && req_write;
  assign x_load = take && !rt_onchip;

  auxram_store #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_store (
    .clk   (clk),
    .we    (ram_we),
    .addr  (rt_ram_addr),
    .wdata (req_wdata),
    .rdata (ram_rdata)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    rdata_d    = rdata_q;
    rdata_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (rt_onchip) begin
            done_d     = 1'b1;
            rdata_load = !req_write;
            rdata_d    = ram_rdata;
          end else begin
            state_d = ST_EXT;
          end
        end
      end
      ST_EXT: begin
        if (ext_ack) begin
          state_d    = ST_IDLE;
          done_d     = 1'b1;
          rdata_load = !xwr_q;
          rdata_d    = ext_rdata;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
      xaddr_q <= '0;
      xwr_q   <= 1'b0;
      xhi_q   <= 1'b0;
      xdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (rdata_load) rdata_q <= rdata_d;
      if (x_load) begin
        xaddr_q <= rt_ext_addr;
        xwr_q   <= req_write;
        xhi_q   <= rt_hi;
        xdata_q <= req_wdata;
      end
    end
  end

  assign ctrl_rd        = ctrl_q;
  assign page_rd        = {{(DATA_W-PAGE_W){1'b0}}, page_q};
  assign rdata          = rdata_q;
  assign done           = done_q;
  assign ext_req        = (state_q == ST_EXT);
  assign ext_addr       = xaddr_q;
  assign ext_write      = xwr_q;
  assign ext_wdata      = xdata_q;
  assign port_ad_active = ext_req || !run_internal;
  assign port_hi_active = (ext_req && xhi_q) || !run_internal;
  assign rd_strobe      = ext_req && !xwr_q;
  assign wr_strobe      = ext_req && xwr_q;
endmodule

// File: rtl/auxram_steer_chk.sv
module auxram_steer_chk #(
  parameter int unsigned BUS_AW = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RAM_AW = 10,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned EN_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ctrl_rd,
  input logic [DATA_W-1:0] page_rd,
  input logic              run_internal,
  input logic              req_valid,
  input logic              req_wide,
  input logic [BUS_AW-1:0] req_dptr,
  input logic              ext_req,
  input logic [BUS_AW-1:0] ext_addr,
  input logic              ext_ack,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic              port_ad_active
);
  localparam int unsigned PAGE_W = RAM_AW - PTR_W;

  a_r3_narrow_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_req && !req_wide && !ctrl_rd[EN_BIT]) |=> !ext_req);

  a_r5_high_dptr_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_req && req_wide && (req_dptr[BUS_AW-1:RAM_AW] != '0))
    |=> (ext_req && ext_addr == $past(req_dptr)));

  a_r6_hit_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_req && run_internal && !ctrl_rd[EN_BIT] &&
     (!req_wide || req_dptr[BUS_AW-1:RAM_AW] == '0))
    |=> (!rd_strobe && !wr_strobe && (!run_internal || !port_ad_active)));

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

  a_r8_page_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    page_rd[DATA_W-1:PAGE_W] == '0);
endmodule

bind auxram_steer auxram_steer_chk #(
  .BUS_AW(BUS_AW), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .PTR_W(PTR_W), .EN_BIT(EN_BIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_rd        (ctrl_rd),
  .page_rd        (page_rd),
  .run_internal   (run_internal),
  .req_valid      (req_valid),
  .req_wide       (req_wide),
  .req_dptr       (req_dptr),
  .ext_req        (ext_req),
  .ext_addr       (ext_addr),
  .ext_ack        (ext_ack),
  .rd_strobe      (rd_strobe),
  .wr_strobe      (wr_strobe),
  .port_ad_active (port_ad_active)
);

// File: tb/auxram_steer_bench.sv
module auxram_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sfr_we, sfr_sel;
  logic [7:0]  sfr_wdata, ctrl_rd, page_rd;
  logic        run_internal, req_valid, req_wide, req_write;
  logic [7:0]  req_ptr, req_wdata, rdata, ext_wdata, ext_rdata;
  logic [15:0] req_dptr, ext_addr;
  logic        done, ext_req, ext_write, ext_ack;
  logic        port_ad_active, port_hi_active, rd_strobe, wr_strobe;

  always #2 clk = ~clk;

  auxram_steer u_auxram_steer (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
    .sfr_wdata(sfr_wdata), .ctrl_rd(ctrl_rd), .page_rd(page_rd),
    .run_internal(run_internal), .req_valid(req_valid), .req_wide(req_wide),
    .req_write(req_write), .req_ptr(req_ptr), .req_dptr(req_dptr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_write(ext_write), .ext_wdata(ext_wdata),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata), .port_ad_active(port_ad_active),
    .port_hi_active(port_hi_active), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [1024];
  logic [7:0] ref_ctrl;
  logic [1:0] ref_page;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_onchip(input bit wide, input logic [15:0] dp);
    return !ref_ctrl[1] && (!wide || dp <= 16'h03FF);
  endfunction

  task automatic sfr_write(input bit sel, input logic [7:0] v);
    @(negedge clk);
    sfr_we = 1'b1; sfr_sel = sel; sfr_wdata = v;
    @(negedge clk);
    sfr_we = 1'b0;
    if (sel) ref_page = v[1:0]; else ref_ctrl = v;
    check(ctrl_rd == ref_ctrl, "R2", ctrl_rd, ref_ctrl);
    check(page_rd == {6'b0, ref_page}, "R8", page_rd, {6'b0, ref_page});
  endtask

  task automatic access(input bit wide, input bit wr, input logic [7:0] ptr,
                        input logic [15:0] dp, input logic [7:0] wd,
                        input int waitc, input bit intrude);
    bit          hit;
    logic [9:0]  raddr;
    logic [15:0] xaddr;
    logic [7:0]  xv;
    hit   = exp_onchip(wide, dp);
    raddr = wide ? dp[9:0] : {ref_page, ptr};
    xaddr = wide ? dp : {8'h00, ptr};
    @(negedge clk);
    check(done == 1'b0, "R9 pulse width", done, 0);
    req_valid = 1'b1; req_wide = wide; req_write = wr;
    req_ptr = ptr; req_dptr = dp; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      check(done == 1'b1, "R9", done, 1);
      check(ext_req == 1'b0, wide ? "R1" : "R3", ext_req, 0);
      check(!rd_strobe && !wr_strobe, "R6 strobes", {rd_strobe, wr_strobe}, 0);
      check(port_ad_active == !run_internal && port_hi_active == !run_internal,
            "R6 ports", {port_ad_active, port_hi_active}, {2{!run_internal}});
      if (wr) ref_mem[raddr] = wd;
      else check(rdata == ref_mem[raddr], wide ? "R1 data" : "R4 data", rdata, ref_mem[raddr]);
    end else begin
      check(ext_req == 1'b1, wide ? "R5" : "R7", ext_req, 1);
      check(ext_addr == xaddr, wide ? "R5 addr" : "R7 addr", ext_addr, xaddr);
      check(ext_write == wr && rd_strobe == !wr && wr_strobe == wr, "R10 dir",
            {ext_write, rd_strobe, wr_strobe}, {wr, !wr, wr});
      if (wr) check(ext_wdata == wd, "R10 wdata", ext_wdata, wd);
      if (run_internal)
        check(port_hi_active == wide, "R7 hi port", port_hi_active, wide);
      for (int i = 0; i < waitc; i++) begin
        if (intrude && i == 0) begin
          req_valid = 1'b1; req_wide = 1'b1; req_write = 1'b1;
          req_dptr = 16'h0005; req_wdata = ~ref_mem[5];
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(ext_req == 1'b1 && ext_addr == xaddr, "R10 hold", ext_addr, xaddr);
        check(done == 1'b0, "R11", done, 0);
      end
      xv = 8'($urandom);
      ext_ack = 1'b1; ext_rdata = xv;
      @(negedge clk);
      ext_ack = 1'b0;
      check(done == 1'b1 && ext_req == 1'b0, "R10 done", {done, ext_req}, 2'b10);
      if (!wr) check(rdata == xv, "R10 rdata", rdata, xv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; sfr_we = 0; sfr_sel = 0; sfr_wdata = 0; run_internal = 1;
    req_valid = 0; req_wide = 0; req_write = 0; req_ptr = 0; req_dptr = 0;
    req_wdata = 0; ext_ack = 0; ext_rdata = 0;
    ref_ctrl = 8'h00; ref_page = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrl_rd == 8'h00, "R2 reset", ctrl_rd, 0);
    check(page_rd == 8'h00, "R8 reset", page_rd, 0);
    check(ext_req == 1'b0 && done == 1'b0, "R10 reset", {ext_req, done}, 0);

    // fill the RAM through the wide form (R1)
    for (int a = 0; a < 1024; a++) access(1'b1, 1'b1, 8'h00, 16'(a), 8'($urandom), 0, 1'b0);

    // window edge (R1, R5)
    access(1'b1, 1'b1, 8'h00, 16'h03FF, 8'hA5, 0, 1'b0);
    access(1'b1, 1'b0, 8'h00, 16'h03FF, 8'h00, 0, 1'b0);
    access(1'b1, 1'b1, 8'h00, 16'h0400, 8'h3C, 2, 1'b0);
    access(1'b1, 1'b0, 8'h00, 16'h0400, 8'h00, 1, 1'b0);

    // page masking (R4, R8)
    sfr_write(1'b1, 8'hFF);
    access(1'b0, 1'b1, 8'h34, 16'h0000, 8'h5E, 0, 1'b0);
    access(1'b1, 1'b0, 8'h00, 16'h0334, 8'h00, 0, 1'b0);
    sfr_write(1'b1, 8'hFD);
    access(1'b0, 1'b0, 8'hFF, 16'h0000, 8'h00, 0, 1'b0);

    // disable bit toggled between accesses (R2, R7)
    sfr_write(1'b0, 8'h02);
    access(1'b0, 1'b0, 8'h34, 16'h0000, 8'h00, 1, 1'b0);
    access(1'b1, 1'b0, 8'h00, 16'h0010, 8'h00, 0, 1'b0);
    sfr_write(1'b0, 8'hFD);
    access(1'b1, 1'b0, 8'h00, 16'h0334, 8'h00, 0, 1'b0);

    // request during a pending external access is dropped (R11)
    access(1'b1, 1'b0, 8'h00, 16'hBEEF, 8'h00, 3, 1'b1);
    access(1'b1, 1'b0, 8'h00, 16'h0005, 8'h00, 0, 1'b0);

    // fetch owns the ports (R6)
    run_internal = 1'b0;
    access(1'b1, 1'b0, 8'h00, 16'h0100, 8'h00, 0, 1'b0);
    run_internal = 1'b1;

    for (int n = 0; n < 400; n++) begin
      int          pick;
      logic [15:0] dp;
      pick = int'($urandom_range(0, 99));
      if (pick < 10) begin
        if ($urandom_range(0, 1) == 0)
          sfr_write(1'b0, ($urandom_range(0, 9) < 3) ? 8'h02 : 8'h00);
        else
          sfr_write(1'b1, 8'($urandom));
      end else begin
        case ($urandom_range(0, 9))
          0, 1, 2, 3, 4: dp = 16'($urandom_range(0, 1023));
          5, 6:          dp = 16'h03F8 + 16'($urandom_range(0, 15));
          default:       dp = 16'($urandom);
        endcase
        run_internal = ($urandom_range(0, 4) != 0);
        begin
          int w;
          w = int'($urandom_range(0, 3));
          access(1'($urandom), 1'($urandom), 8'($urandom), dp, 8'($urandom),
                 w, (w > 0) && ($urandom_range(0, 9) == 0));
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule